// File: doc/BRIEF.md
# Committed Glitch-Free Main Clock Selector

This block picks one of four free-running source clocks and drives it onto a single main clock output. Software chooses a source by writing a 2-bit choice into a pending-choice register. That write does nothing to the output on its own. The choice takes effect only when software arms a separate one-bit commit register: first it writes 0, then it writes 1. The commit is the low-to-high change of the stored commit bit.

Once a choice is committed, the hand-over is glitch-free. The one-hot target is carried into every source domain through a two-flop synchronizer. A gate turns off only on the falling edge of its own clock. A gate turns on, also on its own falling edge, only after every other gate has been seen off. The output is the OR of the four gated sources, so at most one gate is ever open. A busy flag is raised at the commit and stays up until the new gate is the only gate open. A commit that arrives while busy is dropped. If the old or the new source has stopped, the hand-over waits until that clock toggles again.

Register map (2-bit address): 0 holds the pending choice, 1 holds the commit bit, 2 holds status (read-only). Source encoding: 0 is the on-chip RC oscillator, 1 is the PLL reference clock, 2 is the watchdog oscillator, and 3 is the PLL output clock. Each value is the index into `src_clk`.

Top module: `clksel_main`

## Requirements
- R1: After reset, the choice register reads 0, the commit register reads 0 and status reads 0. A few source cycles later, `clk_out` runs at the period of source 0.
- R2: A write to address 0 stores `wr_data[1:0]` as the pending choice. A read of address 0 returns it in bits 1:0 with bits 31:2 zero. A read of address 1 returns the commit bit in bit 0 with bits 31:1 zero.
- R3: Writing the choice register alone never changes the committed source or the `clk_out` period.
- R4: A write to address 1 stores `wr_data[0]`. When the stored bit goes from 0 to 1 while not busy, the pending choice becomes the committed source.
- R5: Writing 1 to address 1 while the stored bit is already 1 commits nothing.
- R6: `busy` rises on the clock edge that takes the commit. It falls once the gate of the committed source is the only open gate. Status (address 2) shows busy in bit 0 and the committed source in bits 2:1, with the rest zero.
- R7: A commit that arrives while busy is ignored, and the committed source stays unchanged.
- R8: After a completed switch, `clk_out` runs at the committed source's period. Every high and every low phase of `clk_out` lasts at least the shortest source half period.
- R9: At most one source gate is open at any time.
- R10: If the new source is stopped, the old gate still closes, `clk_out` rests low with no edges, and busy stays high. The switch completes once the new source runs again.
- R11: If the old source is stopped, `clk_out` shows no edges and busy stays high. The switch completes once the old source runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Register-interface clock |
| rst_n | input | 1 | Synchronous active-low reset, held across several cycles of every source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 choice, 1 commit |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address: 0 choice, 1 commit, 2 status |
| rd_data | output | 32 | Combinational read data |
| src_clk | input | 4 | Source clocks, indexed by the choice encoding |
| clk_out | output | 1 | Selected, glitch-free main clock |
| busy | output | 1 | Switch in progress |

## Verification
Register contents and the rise of busy are due at the first `pclk` edge after the write strobe. The bench drives writes on falling `pclk` edges and reads half a nanosecond after the following falling edge. The end of a switch depends on the synchronizers in the source domains and on the two source clocks, so the bench polls `busy` on falling `pclk` edges, within a bounded cycle budget, before it measures the output. Periods are measured between two rising edges of `clk_out` taken after busy has dropped. Stopped-clock cases are judged over a 100-cycle window that opens only after a 100-cycle settling wait. A monitor times every phase of `clk_out` for the whole run.

// File: rtl/clksel_pkg.sv
// Package: shared address map and source encoding for the main clock selector.
package clksel_pkg;
    localparam int REG_AW = 2;

    // Register addresses decoded by the register block.
    typedef enum logic [REG_AW-1:0] {
        ADDR_SEL  = 2'd0,
        ADDR_UPD  = 2'd1,
        ADDR_STAT = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    // Source encoding; each value is the index into the source clock vector.
    typedef enum logic [1:0] {
        SRC_RC_OSC  = 2'd0,
        SRC_PLL_REF = 2'd1,
        SRC_WD_OSC  = 2'd2,
        SRC_PLL_OUT = 2'd3
    } src_sel_e;
endpackage

// File: rtl/clksel_sync.sv
// Module: clksel_sync
// Multi-flop synchronizer for one level signal into the domain of clk.
// Assumes STAGES >= 2 and that d is a level held far longer than STAGES cycles.
module clksel_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the sampled level down the chain; synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clksel_branch.sv
// Module: clksel_branch
// One gated source. The gate arms only when this source is wanted and no
// other gate is open. The arm request is synchronized on rising edges of the
// source, and the gate enable changes on falling edges, so the output never
// shortens a phase. Assumes reset lasts several cycles of this source.
module clksel_branch #(
    parameter int STAGES = 2
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic want,
    input  logic others_on,
    output logic gate_on,
    output logic clk_gated
);
    logic arm_req;
    logic arm_sync;
    logic en_q;

    assign arm_req = want & ~others_on;

    clksel_sync #(.STAGES(STAGES)) u_sync (
        .clk   (clk_src),
        .rst_n (rst_n),
        .d     (arm_req),
        .q     (arm_sync)
    );

    // Change the gate only while the source is low.
    always_ff @(negedge clk_src) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= arm_sync;
    end

    assign gate_on   = en_q;
    assign clk_gated = clk_src & en_q;
endmodule

// File: rtl/clksel_regs.sv
// Module: clksel_regs
// Register interface in the pclk domain: pending choice, commit bit, commit
// edge detection, committed one-hot target and busy tracking. Gate states
// arrive asynchronously and are synchronized here before busy may drop.
module clksel_regs
    import clksel_pkg::*;
#(
    parameter int NSRC   = 4,
    parameter int SELW   = 2,
    parameter int DW     = 32,
    parameter int STAGES = 2
) (
    input  logic              pclk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic [NSRC-1:0]   gate_on_raw,
    output logic [NSRC-1:0]   want_oh,
    output logic [SELW-1:0]   committed,
    output logic              upd_bit,
    output logic              busy
);
    logic [SELW-1:0] sel_pend;
    logic [SELW-1:0] com_q;
    logic [NSRC-1:0] want_q;
    logic [NSRC-1:0] gate_on_p;
    logic            upd_q;
    logic            busy_q;
    logic            wr_sel;
    logic            wr_upd;
    logic            commit;
    logic            settled;
    logic            unused_wr_hi;

    // Build a one-hot vector from an encoded choice.
    function automatic logic [NSRC-1:0] to_onehot(input logic [SELW-1:0] s);
        logic [NSRC-1:0] v;
        v = '0;
        for (int k = 0; k < NSRC; k++) begin
            if (s == SELW'(k)) v[k] = 1'b1;
        end
        return v;
    endfunction

    // Bring each asynchronous gate state into the pclk domain.
    for (genvar g = 0; g < NSRC; g++) begin : g_gate_sync
        clksel_sync #(.STAGES(STAGES)) u_sync (
            .clk   (pclk),
            .rst_n (rst_n),
            .d     (gate_on_raw[g]),
            .q     (gate_on_p[g])
        );
    end

    assign wr_sel  = wr_en && (wr_addr == ADDR_SEL);
    assign wr_upd  = wr_en && (wr_addr == ADDR_UPD);
    assign commit  = wr_upd && wr_data[0] && !upd_q && !busy_q;
    assign settled = (gate_on_p == want_q);

    // Hold the pending choice and the commit bit as written.
    always_ff @(posedge pclk) begin
        if (!rst_n) begin
            sel_pend <= '0;
            upd_q    <= 1'b0;
        end else begin
            if (wr_sel) sel_pend <= wr_data[SELW-1:0];
            if (wr_upd) upd_q    <= wr_data[0];
        end
    end

    // Take a commit when idle; drop busy once only the target gate is open.
    always_ff @(posedge pclk) begin
        if (!rst_n) begin
            com_q  <= '0;
            want_q <= to_onehot('0);
            busy_q <= 1'b0;
        end else if (commit) begin
            com_q  <= sel_pend;
            want_q <= to_onehot(sel_pend);
            busy_q <= 1'b1;
        end else if (busy_q && settled) begin
            busy_q <= 1'b0;
        end
    end

    // Combinational read mux; reserved bits return zero.
    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(rd_addr))
            ADDR_SEL:  rd_data[SELW-1:0] = sel_pend;
            ADDR_UPD:  rd_data[0]        = upd_q;
            ADDR_STAT: begin
                rd_data[0]      = busy_q;
                rd_data[SELW:1] = com_q;
            end
            default:   rd_data = '0;
        endcase
    end

    assign unused_wr_hi = ^wr_data[DW-1:SELW];

    assign want_oh   = want_q;
    assign committed = com_q;
    assign upd_bit   = upd_q;
    assign busy      = busy_q;
endmodule

// File: rtl/clksel_main.sv
// Module: clksel_main (top)
// Committed glitch-free main clock selector. A register block holds the
// pending choice and commit bit and issues a one-hot target. Each source has
// a gating branch that sees the other gates' states, so no gate opens before
// all others have closed. The output is the OR of the gated sources.
// Assumes every source runs during reset and that reset is held several
// cycles of the slowest source.
module clksel_main
    import clksel_pkg::*;
#(
    parameter int NSRC   = 4,
    parameter int DW     = 32,
    parameter int STAGES = 2
) (
    input  logic              pclk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic [NSRC-1:0]   src_clk,
    output logic              clk_out,
    output logic              busy
);
    localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [NSRC-1:0] want_oh;
    logic [NSRC-1:0] gate_on;
    logic [NSRC-1:0] others_on;
    logic [NSRC-1:0] gated;
    logic [SELW-1:0] committed;
    logic            upd_bit;

    clksel_regs #(
        .NSRC   (NSRC),
        .SELW   (SELW),
        .DW     (DW),
        .STAGES (STAGES)
    ) u_regs (
        .pclk        (pclk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .gate_on_raw (gate_on),
        .want_oh     (want_oh),
        .committed   (committed),
        .upd_bit     (upd_bit),
        .busy        (busy)
    );

    // One gating branch per source; each is blocked while any other is open.
    for (genvar g = 0; g < NSRC; g++) begin : g_branch
        localparam logic [NSRC-1:0] SELF_MASK = NSRC'(1) << g;

        assign others_on[g] = |(gate_on & ~SELF_MASK);

        clksel_branch #(.STAGES(STAGES)) u_branch (
            .clk_src   (src_clk[g]),
            .rst_n     (rst_n),
            .want      (want_oh[g]),
            .others_on (others_on[g]),
            .gate_on   (gate_on[g]),
            .clk_gated (gated[g])
        );
    end

    assign clk_out = |gated;
endmodule

// File: rtl/clksel_main_chk.sv
// Module: clksel_main_chk
// Property checker for clksel_main, attached by bind below. Samples on pclk.
module clksel_main_chk
    import clksel_pkg::*;
#(
    parameter int NSRC = 4,
    parameter int SELW = 2,
    parameter int DW   = 32
) (
    input logic              pclk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [REG_AW-1:0] wr_addr,
    input logic              wr_bit0,
    input logic [REG_AW-1:0] rd_addr,
    input logic [DW-1:0]     rd_data,
    input logic              upd_bit,
    input logic              busy,
    input logic [SELW-1:0]   committed,
    input logic [NSRC-1:0]   gate_on
);
    // R3: a choice write leaves the committed source alone.
    a_r3_sel_write_holds: assert property (@(posedge pclk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_SEL) |=> $stable(committed));

    // R5: rewriting 1 over a stored 1 is not a commit.
    a_r5_no_recommit: assert property (@(posedge pclk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_UPD && wr_bit0 && upd_bit) |=> $stable(committed));

    // R6: busy only rises after a 0-to-1 commit write.
    a_r6_busy_from_commit: assert property (@(posedge pclk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en && wr_addr == ADDR_UPD && wr_bit0 && !upd_bit));

    // R6: status read shows busy and the committed source.
    a_r6_status_view: assert property (@(posedge pclk) disable iff (!rst_n)
        (rd_addr == ADDR_STAT) |-> (rd_data == DW'({committed, busy})));

    // R7: while busy, the committed source is frozen.
    a_r7_busy_locks: assert property (@(posedge pclk) disable iff (!rst_n)
        busy |=> $stable(committed));

    // R9: never more than one gate open.
    a_r9_one_gate: assert property (@(posedge pclk) disable iff (!rst_n)
        $onehot0(gate_on));

    // R2: reserved bits of the choice register read zero.
    a_r2_reserved_zero: assert property (@(posedge pclk) disable iff (!rst_n)
        (rd_addr == ADDR_SEL) |-> (rd_data[DW-1:SELW] == '0));
endmodule

bind clksel_main clksel_main_chk #(
    .NSRC (NSRC),
    .SELW (SELW),
    .DW   (DW)
) u_chk (
    .pclk      (pclk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_bit0   (wr_data[0]),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .upd_bit   (upd_bit),
    .busy      (busy),
    .committed (committed),
    .gate_on   (gate_on)
);

// File: tb/clksel_main_test.sv
`timescale 1ns/1ps
module clksel_main_test;
    logic        pclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    wire  [3:0]  src;
    logic [3:0]  run = 4'hF;
    logic        clk_out;
    logic        busy;

    int vectors = 0;
    int fails   = 0;
    int runts   = 0;
    int edges   = 0;
    bit mon_en  = 0;
    bit done    = 0;
    realtime last_edge = 0.0;

    // Model state
    logic [1:0] m_sel = '0;
    logic       m_upd = 1'b0;
    logic [1:0] m_com = '0;

    always #2 pclk = ~pclk;

    function automatic realtime hp(input int i);
        case (i)
            0: return 5.0;
            1: return 7.0;
            2: return 11.0;
            default: return 3.0;
        endcase
    endfunction

    for (genvar g = 0; g < 4; g++) begin : g_osc
        logic c = 1'b0;
        always begin
            #(hp(g));
            if (run[g]) c = ~c;
        end
        assign src[g] = c;
    end

    clksel_main uut (
        .pclk(pclk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .src_clk(src), .clk_out(clk_out), .busy(busy)
    );

    // Phase timer for R8/R9: every phase at least the shortest half period.
    always @(clk_out) begin
        if (mon_en && ($realtime - last_edge) < 2.99) runts++;
        last_edge = $realtime;
        edges++;
    end

    function automatic logic [31:0] exp_status(input logic b, input logic [1:0] c);
        return {29'b0, c, b};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge pclk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge pclk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 2000; k++) begin
            @(negedge pclk);
            if (!busy) break;
        end
    endtask

    task automatic chk_period(input string req, input logic [1:0] s);
        realtime t0, p;
        @(posedge clk_out); t0 = $realtime;
        @(posedge clk_out); p = $realtime - t0;
        vectors++;
        if (p < 2.0 * hp(s) - 0.01 || p > 2.0 * hp(s) + 0.01) begin
            fails++;
            $display("FAIL %s: actual period %0.2f expected %0.2f", req, p, 2.0 * hp(s));
        end
    endtask

    // Write the commit bit and update the model; returns whether it committed.
    task automatic do_upd(input logic b, input logic [31:0] noise, output bit c);
        c = b && !m_upd;
        wr(2'd1, {noise[31:1], b});
        m_upd = b;
        if (c) m_com = m_sel;
    endtask

    task automatic finish_run();
        vectors++;
        if (runts != 0) begin
            fails++;
            $display("FAIL R8 R9: actual %0d short phases expected 0", runts);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #700000;
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL R8: watchdog expired, actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        bit c;
        int e0;
        void'($urandom(32'h5eed_c10c));
        repeat (40) @(negedge pclk);
        rst_n = 1'b1;
        repeat (100) @(negedge pclk);
        mon_en = 1;

        // R1 reset state
        rd(2'd0, d); chk("R1 choice after reset", d, 32'h0);
        rd(2'd1, d); chk("R1 commit bit after reset", d, 32'h0);
        rd(2'd2, d); chk("R1 status after reset", d, exp_status(1'b0, 2'd0));
        chk_period("R1 source 0 after reset", 2'd0);

        // R2/R3 choice write alone
        wr(2'd0, 32'hFFFF_FFFF); m_sel = 2'd3;
        rd(2'd0, d); chk("R2 choice readback reserved zero", d, 32'h3);
        rd(2'd2, d); chk("R3 committed unchanged by choice write", d, exp_status(1'b0, 2'd0));
        chk_period("R3 period unchanged by choice write", 2'd0);

        // R4/R6 commit to 3
        do_upd(1'b1, 32'hFFFF_FFFE, c);
        rd(2'd2, d); chk("R6 busy right after commit", d, exp_status(1'b1, 2'd3));
        rd(2'd1, d); chk("R2 commit bit readback", d, 32'h1);
        wait_idle();
        rd(2'd2, d); chk("R4 committed source 3", d, exp_status(1'b0, 2'd3));
        chk_period("R8 runs at source 3", 2'd3);

        // R5 rewrite 1
        wr(2'd0, 32'h1); m_sel = 2'd1;
        do_upd(1'b1, 32'h0, c);
        repeat (50) @(negedge pclk);
        rd(2'd2, d); chk("R5 no commit on repeated 1", d, exp_status(1'b0, 2'd3));
        chk_period("R5 period still source 3", 2'd3);

        // R4 0 then 1
        do_upd(1'b0, 32'h0, c);
        do_upd(1'b1, 32'h0, c);
        wait_idle();
        rd(2'd2, d); chk("R4 committed source 1", d, exp_status(1'b0, 2'd1));
        chk_period("R8 runs at source 1", 2'd1);

        // R10 new source stopped; R7 commit while busy
        run[2] = 1'b0;
        wr(2'd0, 32'h2); m_sel = 2'd2;
        do_upd(1'b0, 32'h0, c);
        do_upd(1'b1, 32'h0, c);
        repeat (100) @(negedge pclk);
        e0 = edges;
        repeat (100) @(negedge pclk);
        chk("R10 no output edges while new source stopped", 32'(edges - e0), 32'h0);
        chk("R10 output rests low", {31'b0, clk_out}, 32'h0);
        rd(2'd2, d); chk("R10 busy held", d, exp_status(1'b1, 2'd2));
        wr(2'd0, 32'h3); m_sel = 2'd3;
        wr(2'd1, 32'h0); wr(2'd1, 32'h1); m_upd = 1'b1;
        rd(2'd2, d); chk("R7 commit while busy ignored", d, exp_status(1'b1, 2'd2));
        run[2] = 1'b1;
        wait_idle();
        rd(2'd2, d); chk("R10 completes after restart", d, exp_status(1'b0, 2'd2));
        chk_period("R10 runs at source 2", 2'd2);

        // R11 old source stopped
        run[2] = 1'b0;
        do_upd(1'b0, 32'h0, c);
        do_upd(1'b1, 32'h0, c);
        repeat (100) @(negedge pclk);
        e0 = edges;
        repeat (100) @(negedge pclk);
        chk("R11 no output edges while old source stopped", 32'(edges - e0), 32'h0);
        rd(2'd2, d); chk("R11 busy held", d, exp_status(1'b1, 2'd3));
        run[2] = 1'b1;
        wait_idle();
        rd(2'd2, d); chk("R11 completes after restart", d, exp_status(1'b0, 2'd3));
        chk_period("R11 runs at source 3", 2'd3);

        // Random mix of choice and commit writes
        for (int it = 0; it < 60; it++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[0]) begin
                wr(2'd0, r);
                m_sel = r[3:2];
                wr(2'd0, {r[31:4], m_sel, r[1:0]} >> 2);
                rd(2'd0, d); chk("R2 random choice readback", d, {30'b0, m_sel});
                rd(2'd2, d); chk("R3 random choice write holds source", d, exp_status(1'b0, m_com));
            end else begin
                do_upd(r[1], $urandom, c);
                rd(2'd1, d); chk("R2 random commit bit readback", d, {31'b0, m_upd});
                if (c) begin
                    wait_idle();
                    rd(2'd2, d); chk("R4 random commit", d, exp_status(1'b0, m_com));
                    chk_period("R8 random switch period", m_com);
                end else begin
                    rd(2'd2, d); chk("R5 random non-commit", d, exp_status(1'b0, m_com));
                end
            end
        end

        done = 1;
        finish_run();
    end
endmodule